// File: doc/BRIEF.md
# Pipelined Dual-Port Synchronous RAM

This block is a two-port synchronous static memory with byte-lane writes and a read path two registers deep. Each port carries its own address bus with a load strobe, a pair of chip enables of opposite polarity, a read/write select, and one active-low enable for each 9-bit lane. It also has an output enable that acts without a clock, separate write-data and read-data buses, and one output-valid flag for each lane. The valid flags take the place of tri-state drivers. Both ports share one clock and one synchronous active-high reset, and may reach the array in the same cycle.

A read command sampled at one rising edge puts its data on the output one edge later. Deselecting the port or masking lanes removes the valid flags on that same schedule, so the change follows the edge after the one where it was sampled. This lets two instances share an address bus and tell themselves apart by their chip enables: as the selection moves from one instance to the other, one stops driving in the same cycle the other starts, and there is no cycle where both drive. The output enable gates the valid flags directly, with no clock involved.

The default depth is 1024 words (`ADDR_W` = 10). Setting `ADDR_W` to 16 gives the full 64K-word array. Each word is 18 bits: a lower lane in bits [8:0] and an upper lane in bits [17:9].

Top module: `dpram_pipe2`

## Requirements
- R1: A port is selected only when its `*_cs_n` is 0 and its `*_cs` is 1. With any other combination sampled at an edge, that edge writes nothing through the port, and both of its valid bits are 0 one edge later.
- R2: A selected read (`*_rd` = 1) sampled at edge n shows the stored word on `*_dout` after edge n+1. After edge n alone, the valid bits still reflect the previous slot.
- R3: When `*_ld` = 1, the address bus is used and captured at that edge. When `*_ld` = 0, the last captured address is used again. After reset the captured address is 0.
- R4: A selected write (`*_rd` = 0) updates only the lanes whose `*_lane_n` bit is 0. Bit 0 controls data bits [8:0] and bit 1 controls data bits [17:9].
- R5: `*_vld[i]` is 1 only for a selected read sampled with `*_lane_n[i]` = 0, and only in the slot after edge n+1.
- R6: A write never produces a valid output in its slot.
- R7: With `*_oe_n` = 1, both valid bits of that port are 0 at once, with no clock edge. Returning `*_oe_n` to 0 restores the registered state immediately.
- R8: If the port is deselected, or both lanes are masked, at edge n+1 after a selected read at edge n, the read's data is still valid after edge n+1 and invalid after edge n+2.
- R9: When one port writes an address and the other port reads the same address at the same edge, the read returns the old contents. A later read returns the new contents.
- R10: Reset clears the read pipeline. No valid bit is set until a selected read issued after reset has passed through both stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | ADDR_W | Port A address |
| a_ld | input | 1 | Port A address load strobe |
| a_cs_n | input | 1 | Port A active-low chip enable |
| a_cs | input | 1 | Port A active-high chip enable |
| a_rd | input | 1 | Port A read (1) / write (0) |
| a_lane_n | input | 2 | Port A active-low lane enables |
| a_oe_n | input | 1 | Port A asynchronous active-low output enable |
| a_din | input | 18 | Port A write data |
| a_dout | output | 18 | Port A read data |
| a_vld | output | 2 | Port A per-lane output valid |
| b_addr | input | ADDR_W | Port B address |
| b_ld | input | 1 | Port B address load strobe |
| b_cs_n | input | 1 | Port B active-low chip enable |
| b_cs | input | 1 | Port B active-high chip enable |
| b_rd | input | 1 | Port B read (1) / write (0) |
| b_lane_n | input | 2 | Port B active-low lane enables |
| b_oe_n | input | 1 | Port B asynchronous active-low output enable |
| b_din | input | 18 | Port B write data |
| b_dout | output | 18 | Port B read data |
| b_vld | output | 2 | Port B per-lane output valid |

## Verification
Two functions can land on the same edge. One is a write on one port, and the other is a read on the other port aimed at the same word. A directed case writes a word through port A while port B reads that address on the same edge; port B must return the old value and, on its next read, the new one. Random traffic with a fixed seed also produces such collisions across a 64-word window. There, a bench model that reads before it writes judges every valid lane.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic logic chip_sel(input logic cs_n, input logic cs);
    return (!cs_n) && cs;
  endfunction

endpackage

// File: rtl/dpram_port_ctrl.sv
module dpram_port_ctrl
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ld,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              rd,
  input  logic [LANES-1:0]  lane_n,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              rd_en,
  output logic [LANES-1:0]  wr_lane,
  output logic [LANES-1:0]  rd_lane
);

  logic [ADDR_W-1:0] addr_q;
  acc_e              acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (ld) begin
      addr_q <= addr;
    end
  end

  always_comb begin
    eff_addr = ld ? addr : addr_q;
    if (rst || !chip_sel(cs_n, cs)) begin
      acc = ACC_IDLE;
    end else if (rd) begin
      acc = ACC_READ;
    end else begin
      acc = ACC_WRITE;
    end
    wr_lane = (acc == ACC_WRITE) ? ~lane_n : '0;
    rd_lane = (acc == ACC_READ)  ? ~lane_n : '0;
    rd_en   = |rd_lane;
  end

  // R3: without a load strobe, the address captured at the previous load is reused
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ld |=> (ld || (eff_addr == $past(addr))));

endmodule

// File: rtl/dpram_array.sv
module dpram_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_re,
  input  logic [LANES-1:0]  a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_re,
  input  logic [LANES-1:0]  b_we,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] qa;
    logic [LANE_W-1:0] qb;

    always_ff @(posedge clk) begin
      if (a_we[g]) mem[a_addr] <= a_wdata[g*LANE_W +: LANE_W];
      if (b_we[g]) mem[b_addr] <= b_wdata[g*LANE_W +: LANE_W];
      if (a_re)    qa <= mem[a_addr];
      if (b_re)    qb <= mem[b_addr];
    end

    assign a_rdata[g*LANE_W +: LANE_W] = qa;
    assign b_rdata[g*LANE_W +: LANE_W] = qb;
  end

endmodule

// File: rtl/dpram_out_pipe.sv
module dpram_out_pipe #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  rd_lane,
  input  logic [DATA_W-1:0] rdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  vld
);

  logic [LANES-1:0]  s1_vld;
  logic [LANES-1:0]  s2_vld;
  logic [DATA_W-1:0] dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= '0;
      s2_vld <= '0;
      dout_q <= '0;
    end else begin
      s1_vld <= rd_lane;
      s2_vld <= s1_vld;
      if (|s1_vld) dout_q <= rdata;
    end
  end

  assign dout = dout_q;
  assign vld  = oe_n ? '0 : s2_vld;

endmodule

// File: rtl/dpram_pipe2.sv
module dpram_pipe2
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  localparam int LANES  = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_ld,
  input  logic              a_cs_n,
  input  logic              a_cs,
  input  logic              a_rd,
  input  logic [LANES-1:0]  a_lane_n,
  input  logic              a_oe_n,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  output logic [LANES-1:0]  a_vld,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_ld,
  input  logic              b_cs_n,
  input  logic              b_cs,
  input  logic              b_rd,
  input  logic [LANES-1:0]  b_lane_n,
  input  logic              b_oe_n,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout,
  output logic [LANES-1:0]  b_vld
);

  localparam int NPORT = 2;

  logic [ADDR_W-1:0] p_addr   [NPORT];
  logic              p_ld     [NPORT];
  logic              p_cs_n   [NPORT];
  logic              p_cs     [NPORT];
  logic              p_rd     [NPORT];
  logic [LANES-1:0]  p_lane_n [NPORT];
  logic              p_oe_n   [NPORT];
  logic [DATA_W-1:0] p_din    [NPORT];
  logic [DATA_W-1:0] p_dout   [NPORT];
  logic [LANES-1:0]  p_vld    [NPORT];
  logic [ADDR_W-1:0] p_eff    [NPORT];
  logic              p_re     [NPORT];
  logic [LANES-1:0]  p_we     [NPORT];
  logic [LANES-1:0]  p_rl     [NPORT];
  logic [DATA_W-1:0] p_rdata  [NPORT];

  assign p_addr[0]   = a_addr;   assign p_addr[1]   = b_addr;
  assign p_ld[0]     = a_ld;     assign p_ld[1]     = b_ld;
  assign p_cs_n[0]   = a_cs_n;   assign p_cs_n[1]   = b_cs_n;
  assign p_cs[0]     = a_cs;     assign p_cs[1]     = b_cs;
  assign p_rd[0]     = a_rd;     assign p_rd[1]     = b_rd;
  assign p_lane_n[0] = a_lane_n; assign p_lane_n[1] = b_lane_n;
  assign p_oe_n[0]   = a_oe_n;   assign p_oe_n[1]   = b_oe_n;
  assign p_din[0]    = a_din;    assign p_din[1]    = b_din;
  assign a_dout = p_dout[0];
  assign a_vld  = p_vld[0];
  assign b_dout = p_dout[1];
  assign b_vld  = p_vld[1];

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
    dpram_port_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .addr     (p_addr[gp]),
      .ld       (p_ld[gp]),
      .cs_n     (p_cs_n[gp]),
      .cs       (p_cs[gp]),
      .rd       (p_rd[gp]),
      .lane_n   (p_lane_n[gp]),
      .eff_addr (p_eff[gp]),
      .rd_en    (p_re[gp]),
      .wr_lane  (p_we[gp]),
      .rd_lane  (p_rl[gp])
    );

    dpram_out_pipe #(.LANES(LANES), .LANE_W(LANE_W)) u_pipe (
      .clk     (clk),
      .rst     (rst),
      .rd_lane (p_rl[gp]),
      .rdata   (p_rdata[gp]),
      .oe_n    (p_oe_n[gp]),
      .dout    (p_dout[gp]),
      .vld     (p_vld[gp])
    );

    // R1: a deselected port shows no valid lane in the slot it would own
    p_desel_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      !chip_sel(p_cs_n[gp], p_cs[gp]) |-> ##2 (p_vld[gp] == '0));

    // R6: a write leaves its slot without valid output
    p_write_silent_r6: assert property (@(posedge clk) disable iff (rst)
      (chip_sel(p_cs_n[gp], p_cs[gp]) && !p_rd[gp]) |-> ##2 (p_vld[gp] == '0));

    // R10: nothing is valid on the first cycle after reset
    p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (p_vld[gp] == '0));

    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane_chk
      // R5: a masked lane stays invalid for its slot
      p_lane_off_r5: assert property (@(posedge clk) disable iff (rst)
        p_lane_n[gp][gl] |-> ##2 !p_vld[gp][gl]);
    end
  end

  dpram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .a_addr  (p_eff[0]),
    .a_re    (p_re[0]),
    .a_we    (p_we[0]),
    .a_wdata (p_din[0]),
    .a_rdata (p_rdata[0]),
    .b_addr  (p_eff[1]),
    .b_re    (p_re[1]),
    .b_we    (p_we[1]),
    .b_wdata (p_din[1]),
    .b_rdata (p_rdata[1])
  );

endmodule

// File: tb/dpram_pipe2_tb.sv
`timescale 1ns/1ps
module dpram_pipe2_tb;

  localparam int ADDR_W = 10;
  localparam int DW     = 18;
  localparam int WIN    = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [ADDR_W-1:0] t_addr [2];
  logic              t_ld [2], t_cs_n [2], t_cs [2], t_rd [2], t_oe_n [2];
  logic [1:0]        t_lane_n [2];
  logic [DW-1:0]     t_din [2];
  logic [DW-1:0]     o_dout [2];
  logic [1:0]        o_vld [2];

  dpram_pipe2 #(.ADDR_W(ADDR_W), .LANE_W(9)) u_dut (
    .clk(clk), .rst(rst),
    .a_addr(t_addr[0]), .a_ld(t_ld[0]), .a_cs_n(t_cs_n[0]), .a_cs(t_cs[0]),
    .a_rd(t_rd[0]), .a_lane_n(t_lane_n[0]), .a_oe_n(t_oe_n[0]), .a_din(t_din[0]),
    .a_dout(o_dout[0]), .a_vld(o_vld[0]),
    .b_addr(t_addr[1]), .b_ld(t_ld[1]), .b_cs_n(t_cs_n[1]), .b_cs(t_cs[1]),
    .b_rd(t_rd[1]), .b_lane_n(t_lane_n[1]), .b_oe_n(t_oe_n[1]), .b_din(t_din[1]),
    .b_dout(o_dout[1]), .b_vld(o_vld[1])
  );

  // bench model
  logic [DW-1:0]     m_mem [WIN];
  logic [ADDR_W-1:0] m_areg [2];
  logic [1:0]        s1v [2], s2v [2];
  logic [DW-1:0]     s1d [2], s2d [2];

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 32'h9E37 + salt * 32'h51) ^ (a << 5));
  endfunction

  function automatic logic [ADDR_W-1:0] eff_of(input int p);
    return t_ld[p] ? t_addr[p] : m_areg[p];
  endfunction

  task automatic set_idle(input int p);
    t_addr[p] = '0; t_ld[p] = 1'b0; t_cs_n[p] = 1'b1; t_cs[p] = 1'b0;
    t_rd[p] = 1'b1; t_lane_n[p] = 2'b11; t_oe_n[p] = 1'b0; t_din[p] = '0;
  endtask

  task automatic set_rd(input int p, input int a, input logic [1:0] ln);
    t_addr[p] = ADDR_W'(a); t_ld[p] = 1'b1; t_cs_n[p] = 1'b0; t_cs[p] = 1'b1;
    t_rd[p] = 1'b1; t_lane_n[p] = ln;
  endtask

  task automatic set_wr(input int p, input int a, input logic [DW-1:0] d, input logic [1:0] ln);
    t_addr[p] = ADDR_W'(a); t_ld[p] = 1'b1; t_cs_n[p] = 1'b0; t_cs[p] = 1'b1;
    t_rd[p] = 1'b0; t_lane_n[p] = ln; t_din[p] = d;
  endtask

  // advance the model across one edge, then sample 1 ns after it
  task automatic tick();
    logic [ADDR_W-1:0] ea [2];
    logic              sel [2];
    for (int p = 0; p < 2; p++) begin
      ea[p]  = eff_of(p);
      sel[p] = !rst && !t_cs_n[p] && t_cs[p];
      s2v[p] = s1v[p];
      s2d[p] = s1d[p];
      s1v[p] = (sel[p] && t_rd[p]) ? ~t_lane_n[p] : 2'b00;
      if (s1v[p] != 2'b00) s1d[p] = m_mem[ea[p][5:0]];
      if (rst) begin
        s1v[p] = 2'b00; s2v[p] = 2'b00; m_areg[p] = '0;
      end else if (t_ld[p]) begin
        m_areg[p] = t_addr[p];
      end
    end
    for (int p = 0; p < 2; p++) begin
      if (sel[p] && !t_rd[p]) begin
        if (!t_lane_n[p][0]) m_mem[ea[p][5:0]][8:0]  = t_din[p][8:0];
        if (!t_lane_n[p][1]) m_mem[ea[p][5:0]][17:9] = t_din[p][17:9];
      end
    end
    @(posedge clk);
    #1;
  endtask

  task automatic check_port(input int p, input string tag);
    for (int l = 0; l < 2; l++) begin
      logic ev;
      ev = t_oe_n[p] ? 1'b0 : s2v[p][l];
      n_cmp++;
      if (o_vld[p][l] !== ev) begin
        n_bad++;
        $display("FAIL %s port%0d lane%0d valid: got %0b expected %0b", tag, p, l, o_vld[p][l], ev);
      end else if (ev) begin
        n_cmp++;
        if (o_dout[p][l*9 +: 9] !== s2d[p][l*9 +: 9]) begin
          n_bad++;
          $display("FAIL %s port%0d lane%0d data: got %h expected %h",
                   tag, p, l, o_dout[p][l*9 +: 9], s2d[p][l*9 +: 9]);
        end
      end
    end
  endtask

  task automatic step(input string tag);
    tick();
    check_port(0, tag);
    check_port(1, tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h00C0FFEE);
    for (int i = 0; i < WIN; i++) m_mem[i] = '0;
    for (int p = 0; p < 2; p++) begin
      set_idle(p); m_areg[p] = '0; s1v[p] = '0; s2v[p] = '0; s1d[p] = '0; s2d[p] = '0;
    end
    rst = 1'b1;
    // reads requested during reset must not leak out (R10)
    set_rd(0, 1, 2'b00);
    repeat (3) step("R10 in reset");
    rst = 1'b0;
    set_idle(0);
    step("R10 after reset");
    step("R10 after reset");

    // prefill the 64-word window through port A (R6: writes stay silent)
    for (int a = 0; a < WIN; a++) begin
      set_wr(0, a, pat(a, 1), 2'b00);
      step("R6 prefill write");
    end
    set_idle(0);
    step("R6 drain");
    step("R6 drain");

    // R2 latency: read issued at edge n, valid after edge n+1
    set_rd(0, 5, 2'b00);
    step("R2 edge n");
    set_idle(0);
    step("R2 edge n+1");
    step("R2 slot end");

    // R3: load address 7, then keep reading with strobe low and a different bus value
    set_rd(0, 7, 2'b00);
    step("R3 load");
    t_ld[0] = 1'b0; t_addr[0] = ADDR_W'(40);
    step("R3 hold");
    step("R3 hold");
    set_idle(0);
    step("R3 drain");
    step("R3 drain");

    // R4: write only the upper lane of word 9, then only the lower lane of word 10
    set_wr(0, 9, 18'h3FFFF, 2'b01);
    step("R4 upper write");
    set_wr(0, 10, 18'h2AAAA, 2'b10);
    step("R4 lower write");
    set_rd(0, 9, 2'b00);
    step("R4 read back");
    set_rd(0, 10, 2'b00);
    step("R4 read back");
    set_idle(0);
    step("R4 read back");
    step("R4 read back");

    // R5: lower-lane-only read, then upper-lane-only read
    set_rd(0, 11, 2'b10);
    step("R5 lane mask");
    set_rd(0, 12, 2'b01);
    step("R5 lane mask");
    set_idle(0);
    step("R5 lane mask");
    step("R5 lane mask");

    // R8 / R1: deselect by each chip enable and by masking both lanes
    for (int k = 0; k < 3; k++) begin
      set_rd(0, 13 + k, 2'b00);
      step("R8 read");
      if (k == 0) t_cs_n[0] = 1'b1;
      else if (k == 1) t_cs[0] = 1'b0;
      else t_lane_n[0] = 2'b11;
      step("R8 data still valid");
      step("R1 deselect takes effect");
      set_idle(0);
      step("R1 idle");
    end

    // R7: output enable toggled between edges
    set_rd(0, 20, 2'b00);
    step("R7 setup");
    set_idle(0);
    step("R7 valid slot");
    #0.5 t_oe_n[0] = 1'b1;
    #0.5 check_port(0, "R7 oe off");
    t_oe_n[0] = 1'b0;
    #0.5 check_port(0, "R7 oe on");
    step("R7 tail");

    // R9: port A writes word 30 while port B reads it at the same edge
    set_wr(0, 30, 18'h15555, 2'b00);
    set_rd(1, 30, 2'b00);
    step("R9 collide");
    set_idle(0);
    step("R9 old data");
    step("R9 reread");
    set_idle(1);
    step("R9 new data");
    step("R9 drain");

    // constrained random traffic over the window on both ports
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < 2; p++) begin
        t_ld[p]     = ($urandom % 4) != 0;
        t_addr[p]   = ADDR_W'($urandom % WIN);
        t_cs_n[p]   = ($urandom % 6) == 0;
        t_cs[p]     = ($urandom % 7) != 0;
        t_rd[p]     = ($urandom % 3) != 0;
        t_lane_n[p] = 2'($urandom);
        t_oe_n[p]   = ($urandom % 8) == 0;
        t_din[p]    = DW'($urandom);
      end
      if (!t_rd[0] && !t_rd[1] && (eff_of(0) == eff_of(1))) t_rd[1] = 1'b1;
      step("R2 R5 R9 random");
    end

    done = 1;
    summary();
  end

endmodule